// File: doc/BRIEF.md
# Buffered Serial Character Receiver with Parity Check

This block takes in asynchronous serial characters on a single line that idles high. Each character is a low start bit, a run of data bits sent least-significant first, one parity bit and one or more high stop bits. The frame format is set by four parameters, the same set a matching transmitter uses: clocks per bit, data bits, total bits per character and parity sense. A falling edge on the idle line starts a character. The line is sampled in the middle of each bit. The data bits are collected in a shift register and then copied into a holding register.

When a character is complete the block raises a buffer-full flag. It then stays deaf to the line until the consumer pulses the read input. The held word is presented zero-extended on a 16-bit output so that it can drive a four-digit hexadecimal display directly. A parity-error flag is updated from the held word and its parity bit while buffer-full is high. It keeps its value until reset or until the next character.

Top module: `serial_char_rx`

## Requirements
- R1: Reception begins only on a 1-to-0 transition of `rx_in` seen in the idle state. A line held low after a character does not start a further character.
- R2: Counting from the first clock edge that sees the line low, bit k of the frame (start bit k=0) is sampled at edge CYC_PER_BIT/2 + k*CYC_PER_BIT. A bit value that is valid only in a window of plus or minus two clocks around that point is received correctly.
- R3: Data bits arrive least-significant first. After a full frame, `data_out` holds the received word.
- R4: If `rx_in` is high again at the start-bit sampling point, the block returns to idle and raises nothing.
- R5: `par_err` loads while `buf_full` is high. With ODD_PAR=1 it is set when the number of ones in the data bits plus the parity bit is even; with ODD_PAR=0 it is set when that number is odd. It keeps its value while `buf_full` is low and changes only with the next character.
- R6: Bits 15 down to DATA_W of `data_out` are always zero.
- R7: `buf_full` stays high until `rd_buf` is sampled high, and is low on the next clock.
- R8: A character sent while `buf_full` is high is ignored: `data_out` is unchanged and no further `buf_full` follows the read.
- R9: After reset, `buf_full` and `par_err` are 0 and `data_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Serial line, idles high |
| rd_buf | input | 1 | Consumer has taken the held word; releases the buffer |
| data_out | output | 16 | Held word, zero-extended |
| buf_full | output | 1 | A received word is waiting |
| par_err | output | 1 | Parity of the last received character was wrong |

## Verification
The assertions take `rx_in` to be already synchronous to `clk`. They also assume a stop bit per frame that leaves the line high before the next start edge. The bench keeps within this by changing `rx_in` and `rd_buf` only at falling clock edges. It builds every frame bit from exactly CYC_PER_BIT clocks and, except in the held-low case, returns the line high after each frame. Deliberately malformed stimulus is limited to a short start glitch, shrunken bit windows and a line held low. These are the cases the requirements name.

// File: rtl/serial_char_rx.sv
module serial_char_rx #(
  parameter int CYC_PER_BIT = 16,
  parameter int DATA_W      = 12,
  parameter int FRAME_BITS  = 15,
  parameter bit ODD_PAR     = 1'b1
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_in,
  input  logic        rd_buf,
  output logic [15:0] data_out,
  output logic        buf_full,
  output logic        par_err
);
  localparam int HALF = CYC_PER_BIT / 2;
  localparam int CW   = $clog2(CYC_PER_BIT);
  localparam int BW   = $clog2(FRAME_BITS);

  typedef enum logic [2:0] {IDLE, HUNT, SHIFT, COPY, FULL} st_t;

  st_t               st;
  logic              rx_d;
  logic              start;
  logic [CW-1:0]     bt;
  logic [BW-1:0]     bc;
  logic [DATA_W-1:0] sr, br;
  logic              ps, pb;

  assign start    = rx_d & ~rx_in;
  assign buf_full = (st == FULL);
  assign data_out = 16'(br);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= IDLE;
      rx_d <= 1'b1;
      bt   <= '0;
      bc   <= '0;
      sr   <= '0;
      br   <= '0;
      ps   <= 1'b0;
      pb   <= 1'b0;
    end else begin
      rx_d <= rx_in;
      case (st)
        IDLE: if (start) begin
          st <= HUNT;
          bt <= '0;
        end
        HUNT: if (bt == CW'(HALF - 1)) begin
          bt <= '0;
          bc <= '0;
          st <= rx_in ? IDLE : SHIFT;
        end else bt <= bt + 1'b1;
        SHIFT: if (bt == CW'(CYC_PER_BIT - 1)) begin
          bt <= '0;
          bc <= bc + 1'b1;
          if (bc < BW'(DATA_W)) sr <= {rx_in, sr[DATA_W-1:1]};
          else if (bc == BW'(DATA_W)) ps <= rx_in;
          if (bc == BW'(FRAME_BITS - 2)) st <= COPY;
        end else bt <= bt + 1'b1;
        COPY: begin
          br <= sr;
          pb <= ps;
          st <= FULL;
        end
        FULL: if (rd_buf) st <= IDLE;
        default: st <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           par_err <= 1'b0;
    else if (buf_full) par_err <= (^br ^ pb) ^ ODD_PAR;
  end

  AST_EDGE_STARTS: assert property (@(posedge clk) disable iff (rst)
    (st == IDLE && rx_d && !rx_in) |=> (st == HUNT)); // R1
  AST_GLITCH_DROPS: assert property (@(posedge clk) disable iff (rst)
    (st == HUNT && bt == CW'(HALF - 1) && rx_in) |=> (st == IDLE && !buf_full)); // R4
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !rd_buf) |=> $stable(data_out)); // R3
  AST_PERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!buf_full) |=> $stable(par_err)); // R5
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((data_out >> DATA_W) == 16'd0)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (buf_full && !rd_buf) |=> buf_full); // R7
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (buf_full && rd_buf) |=> !buf_full); // R7
  AST_DEAF_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    (buf_full && start && !rd_buf) |=> (buf_full && $stable(data_out))); // R8
endmodule

// File: tb/test_serial_char_rx.sv
module test_serial_char_rx;
  localparam int CPB = 16;
  localparam int DW = 12;
  localparam int FB = 15;
  localparam int HALF = CPB / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic rd_buf = 1'b0;
  logic [15:0] data_out;
  logic buf_full, par_err;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  serial_char_rx #(.CYC_PER_BIT(CPB), .DATA_W(DW), .FRAME_BITS(FB), .ODD_PAR(1'b1)) i_serial_char_rx (
    .clk(clk), .rst(rst), .rx_in(rx_in), .rd_buf(rd_buf),
    .data_out(data_out), .buf_full(buf_full), .par_err(par_err));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [DW-1:0] d, input logic bad_par, input logic narrow);
    logic v;
    for (int k = 0; k < FB; k++) begin
      if (k == 0) v = 1'b0;
      else if (k <= DW) v = d[k-1];
      else if (k == DW + 1) v = (~^d) ^ bad_par;
      else v = 1'b1;
      for (int c = 0; c < CPB; c++) begin
        @(negedge clk);
        rx_in = (narrow && k > 0 && k <= DW + 1 && (c < HALF - 2 || c > HALF + 2)) ? ~v : v;
      end
    end
    @(negedge clk);
    rx_in = 1'b1;
  endtask

  task automatic read_buf;
    @(negedge clk);
    rd_buf = 1'b1;
    @(negedge clk);
    rd_buf = 1'b0;
    chk("R7 buf_full cleared by read", 32'(buf_full), 32'd0);
  endtask

  task automatic t_reset;
    idle(3);
    rst = 1'b0;
    idle(2);
    chk("R9 buf_full after reset", 32'(buf_full), 32'd0);
    chk("R9 par_err after reset", 32'(par_err), 32'd0);
    chk("R9 data_out after reset", 32'(data_out), 32'd0);
  endtask

  task automatic t_word(input logic [DW-1:0] d);
    send(d, 1'b0, 1'b0);
    idle(2);
    chk("R3 buf_full after frame", 32'(buf_full), 32'd1);
    chk("R3 received word", 32'(data_out), 32'(d));
    chk("R6 upper bits zero", 32'(data_out[15:DW]), 32'd0);
    chk("R5 good parity", 32'(par_err), 32'd0);
    idle(5);
    chk("R7 buf_full held without read", 32'(buf_full), 32'd1);
    read_buf();
  endtask

  task automatic t_parity;
    send(12'h3C1, 1'b1, 1'b0);
    idle(2);
    chk("R5 parity error set", 32'(par_err), 32'd1);
    read_buf();
    idle(20);
    chk("R5 parity error held while empty", 32'(par_err), 32'd1);
    send(12'h3C1, 1'b0, 1'b0);
    idle(2);
    chk("R5 parity error cleared by next char", 32'(par_err), 32'd0);
    read_buf();
  endtask

  task automatic t_glitch;
    @(negedge clk);
    rx_in = 1'b0;
    idle(3);
    rx_in = 1'b1;
    idle(3 * CPB * FB);
    chk("R4 glitch raises nothing", 32'(buf_full), 32'd0);
    send(12'h5A6, 1'b0, 1'b0);
    idle(2);
    chk("R4 next char after glitch", 32'(data_out), 32'h5A6);
    read_buf();
  endtask

  task automatic t_midpoint;
    send(12'h9B3, 1'b0, 1'b1);
    idle(2);
    chk("R2 mid-bit sampled word", 32'(data_out), 32'h9B3);
    chk("R2 mid-bit sampled parity", 32'(par_err), 32'd0);
    read_buf();
  endtask

  task automatic t_deaf;
    send(12'h456, 1'b0, 1'b0);
    idle(2);
    send(12'h123, 1'b0, 1'b0);
    idle(2);
    chk("R8 data unchanged while full", 32'(data_out), 32'h456);
    read_buf();
    idle(2 * CPB * FB);
    chk("R8 ignored char gives no buf_full", 32'(buf_full), 32'd0);
  endtask

  task automatic t_held_low;
    @(negedge clk);
    rx_in = 1'b0;
    idle(CPB * FB + 4);
    chk("R1 low line gives one char", 32'(buf_full), 32'd1);
    chk("R1 low line word", 32'(data_out), 32'd0);
    read_buf();
    idle(2 * CPB * FB);
    chk("R1 no second char while held low", 32'(buf_full), 32'd0);
    rx_in = 1'b1;
    idle(4);
  endtask

  initial begin
    t_reset();
    t_word(12'hA5C);
    t_word(12'hFFF);
    t_word(12'h000);
    t_word(12'h801);
    t_parity();
    t_glitch();
    t_midpoint();
    t_deaf();
    t_held_low();
    t_word(12'h7E2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule